// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Two Priority Groups

This block collects fifteen interrupt request lines, numbered 1 to 15, and gives each of up to four processors a 4-bit interrupt level. Software programs it through a 32-bit APB-style register port. A shared pending register records requests that every processor may take. A broadcast register can instead steer a line into every processor's private force register. Each processor has its own mask, which selects the lines it listens to. A group register places each line in either a high or a low priority group.

For every processor the block forms the active set from pending, that processor's force bits and its mask. It picks the high group if any of its lines are active, and otherwise the low group. Within the chosen group the highest line number becomes the processor's level, and 0 means idle. A processor reports the line it took on its acknowledge input, which withdraws that line from the shared pending register and from that processor's force register.

Top module: `mp_irq_ctrl`

## Requirements
- R1: Bit 0 of every line vector is reserved. Writes to the group, alias, clear, broadcast, mask and force registers drop it, and it never reads back as 1 in pending or force.
- R2: Only address bits [7:2] are decoded. Word 0x00 is the group register, 0x04 pending, 0x08 the processor-0 force alias, 0x0C clear, 0x10 status and 0x14 broadcast. The per-processor banks are mask at 0x40+4n, force at 0x80+4n and extended at 0xC0+4n. The extended register keeps bits [3:0]. Unmapped words and slots n at or above the processor count read 0 and ignore writes.
- R3: The active set of processor n is (pending OR force[n]) AND mask[n], so a processor with mask 0 has level 0.
- R4: Active lines whose group bit is 1 beat all active lines whose group bit is 0. Within the chosen group the output level is the highest active line number.
- R5: On a rising request edge of line k, bit k is set in every force register if broadcast bit k is 1, and otherwise it is set in pending. On a falling edge the bit is cleared from the same place.
- R6: A write to a per-processor force register sets the bits in [15:1] and then clears the bits named in [31:17]: new = (old OR set) AND NOT clear.
- R7: Writing the clear register removes the named pending bits. Clear and status always read 0, and writes to the pending word change nothing.
- R8: An acknowledge from processor n with line number k clears pending bit k and force[n] bit k in the same clock.
- R9: A write to the alias word 0x08 replaces processor 0's force register with bits [15:1] of the data.
- R10: If an acknowledge and a new rising edge hit the same bit in the same clock, the bit ends up set.
- R11: Reset clears every register, so every level output is 0.
- R12: Level outputs are registered. A state change made at one clock edge shows on the level outputs at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a register transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address, bits [7:2] decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| irq_in | input | 16 | Request lines, bit 0 unused |
| ack_valid | input | NCPU | Per-processor acknowledge strobe |
| ack_num | input | 4*NCPU | Per-processor acknowledged line number |
| cpu_level | output | 4*NCPU | Per-processor interrupt level, 0 when idle |

## Verification
The hardest case to reach from the ports is a single clock in which an acknowledge and a fresh rising edge land on the same bit. It is equally hard to get a mix of broadcast and shared lines split across both priority groups, with different masks per processor. Directed steps first build each of these states explicitly, including the collision. Randomly seeded operations then interleave line toggles, acknowledges with simultaneous toggles, and writes and reads at any word address, including unmapped words and absent slots. After every operation the four levels are compared with a reference model in the bench.

// File: rtl/irqc_pkg.sv
// Shared constants and types for the multiprocessor interrupt controller.
// Assumes 16-bit line vectors in which bit 0 is reserved.
package irqc_pkg;
    localparam int unsigned NLINE  = 16;
    localparam int unsigned LVL_W  = $clog2(NLINE);
    localparam int unsigned WORD_W = 6;
    localparam int unsigned SLOT_W = 4;

    typedef logic [NLINE-1:0] vec_t;

    localparam vec_t LINE_MASK = vec_t'(16'hFFFE);

    // Word selectors inside the global bank (address bits [7:2]).
    typedef enum logic [WORD_W-1:0] {
        W_GROUP = 6'h00,
        W_PEND  = 6'h01,
        W_ALIAS = 6'h02,
        W_CLEAR = 6'h03,
        W_STAT  = 6'h04,
        W_BCAST = 6'h05
    } gword_e;

    // Bank selectors (address bits [7:6]).
    localparam logic [1:0] BANK_GLOBAL = 2'd0;
    localparam logic [1:0] BANK_MASK   = 2'd1;
    localparam logic [1:0] BANK_FORCE  = 2'd2;
    localparam logic [1:0] BANK_EXT    = 2'd3;
endpackage

// File: rtl/irqc_edge.sv
// Request edge finder: samples the request lines once per clock and flags
// rising and falling edges against the previous sample.
// Assumes request lines are already synchronous to clk.
module irqc_edge
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vec_t req,
    output vec_t rise,
    output vec_t fall
);
    vec_t req_q;

    // Hold the previous sample of the request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req & LINE_MASK;
    end

    assign rise = req  & ~req_q & LINE_MASK;
    assign fall = ~req &  req_q & LINE_MASK;
endmodule

// File: rtl/irqc_regfile.sv
// Register file: decodes the register port and holds the group, pending,
// broadcast and per-processor mask, force and extended registers. It also
// applies request edges and acknowledges.
// Assumes ADDR_W > 8. Only address bits [7:2] are decoded.
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int unsigned NCPU   = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    psel,
    input  logic                    penable,
    input  logic                    pwrite,
    input  logic [ADDR_W-1:0]       paddr,
    input  logic [31:0]             pwdata,
    output logic [31:0]             prdata,
    input  vec_t                    rise,
    input  vec_t                    fall,
    input  logic [NCPU-1:0]         ack_valid,
    input  logic [NCPU*LVL_W-1:0]   ack_num,
    output vec_t                    group_o,
    output vec_t                    pend_o,
    output vec_t                    bcast_o,
    output logic [NCPU*NLINE-1:0]   mask_o,
    output logic [NCPU*NLINE-1:0]   force_o
);
    localparam int unsigned EXT_W = 4;

    vec_t group_q, pend_q, bcast_q;
    logic [NCPU*NLINE-1:0] ack_flat;
    logic [NCPU*EXT_W-1:0] ext_flat;
    vec_t ack_all;

    logic              wr_en;
    logic [WORD_W-1:0] word;
    logic [1:0]        bank;
    logic [SLOT_W-1:0] slot;
    logic              unused_bits;

    assign wr_en = psel & penable & pwrite;
    assign word  = paddr[7:2];
    assign bank  = paddr[7:6];
    assign slot  = paddr[5:2];
    assign unused_bits = ^{paddr[ADDR_W-1:8], paddr[1:0]};

    logic wr_group, wr_alias, wr_clear, wr_bcast;
    assign wr_group = wr_en && (word == W_GROUP);
    assign wr_alias = wr_en && (word == W_ALIAS);
    assign wr_clear = wr_en && (word == W_CLEAR);
    assign wr_bcast = wr_en && (word == W_BCAST);

    vec_t wset, wclr, rise_bc, rise_pd, fall_bc, fall_pd, clr_vec;
    assign wset    = pwdata[15:0]  & LINE_MASK;
    assign wclr    = pwdata[31:16] & LINE_MASK;
    assign rise_bc = rise &  bcast_q;
    assign rise_pd = rise & ~bcast_q;
    assign fall_bc = fall &  bcast_q;
    assign fall_pd = fall & ~bcast_q;
    assign clr_vec = wr_clear ? wset : '0;

    // Combine all processors' acknowledge clears for the shared register.
    always_comb begin
        ack_all = '0;
        for (int n = 0; n < NCPU; n++) ack_all |= ack_flat[n*NLINE +: NLINE];
    end

    // Group and broadcast registers: plain software-written state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            group_q <= '0;
            bcast_q <= '0;
        end else begin
            if (wr_group) group_q <= wset;
            if (wr_bcast) bcast_q <= wset;
        end
    end

    // Shared pending: clears first, then a new non-broadcast edge sets.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec & ~ack_all & ~fall_pd) | rise_pd;
    end

    for (genvar n = 0; n < NCPU; n++) begin : g_cpu
        localparam bit IS_CPU0 = (n == 0);
        vec_t mask_r, force_r, force_nx, ack_v;
        logic [EXT_W-1:0] ext_r;
        logic wr_mask, wr_force, wr_ext;

        assign wr_mask  = wr_en && (bank == BANK_MASK)  && (slot == SLOT_W'(n));
        assign wr_force = wr_en && (bank == BANK_FORCE) && (slot == SLOT_W'(n));
        assign wr_ext   = wr_en && (bank == BANK_EXT)   && (slot == SLOT_W'(n));
        assign ack_v    = ack_valid[n]
                        ? ((vec_t'(1) << ack_num[n*LVL_W +: LVL_W]) & LINE_MASK)
                        : '0;

        // Next force value: software write, then acknowledge and edge updates.
        always_comb begin
            force_nx = force_r;
            if (wr_force)            force_nx = (force_nx | wset) & ~wclr;
            if (IS_CPU0 && wr_alias) force_nx = wset;
            force_nx = (force_nx & ~ack_v & ~fall_bc) | rise_bc;
        end

        // Per-processor mask, force and extended registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_r  <= '0;
                force_r <= '0;
                ext_r   <= '0;
            end else begin
                if (wr_mask) mask_r <= wset;
                if (wr_ext)  ext_r  <= pwdata[EXT_W-1:0];
                force_r <= force_nx;
            end
        end

        assign mask_o  [n*NLINE +: NLINE] = mask_r;
        assign force_o [n*NLINE +: NLINE] = force_r;
        assign ack_flat[n*NLINE +: NLINE] = ack_v;
        assign ext_flat[n*EXT_W +: EXT_W] = ext_r;
    end

    // Read multiplexer: zero for unmapped words and absent slots.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (bank == BANK_GLOBAL) begin
                case (word)
                    W_GROUP: prdata = {16'h0, group_q};
                    W_PEND:  prdata = {16'h0, pend_q};
                    W_ALIAS: prdata = {16'h0, force_o[NLINE-1:0]};
                    W_BCAST: prdata = {16'h0, bcast_q};
                    default: prdata = '0;
                endcase
            end else begin
                for (int n = 0; n < NCPU; n++) begin
                    if (slot == SLOT_W'(n)) begin
                        case (bank)
                            BANK_MASK:  prdata = {16'h0, mask_o[n*NLINE +: NLINE]};
                            BANK_FORCE: prdata = {16'h0, force_o[n*NLINE +: NLINE]};
                            BANK_EXT:   prdata = {28'h0, ext_flat[n*EXT_W +: EXT_W]};
                            default:    prdata = '0;
                        endcase
                    end
                end
            end
        end
    end

    assign group_o = group_q;
    assign pend_o  = pend_q;
    assign bcast_o = bcast_q;
endmodule

// File: rtl/irqc_prio.sv
// Per-processor level selector: forms the active set, prefers the high
// group, and registers the highest active line number in that group.
// Assumes all inputs are registered state with bit 0 held at zero.
module irqc_prio
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  vec_t             pend,
    input  vec_t             frc,
    input  vec_t             mask,
    input  vec_t             group,
    output logic [LVL_W-1:0] level_o
);
    vec_t act, hi, pick;
    logic [LVL_W-1:0] enc;

    assign act  = (pend | frc) & mask;
    assign hi   = act & group;
    assign pick = (|hi) ? hi : (act & ~group);

    // Encode the highest set line of the chosen group.
    always_comb begin
        enc = '0;
        for (int i = 1; i < NLINE; i++) if (pick[i]) enc = LVL_W'(i);
    end

    // Register the level so it follows state by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) level_o <= '0;
        else        level_o <= enc;
    end
endmodule

// File: rtl/mp_irq_ctrl.sv
// Top of the multiprocessor interrupt controller. It connects the edge
// finder, the register file and one level selector per processor.
// Assumes 1 <= NCPU <= 4 and ADDR_W > 8.
module mp_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NCPU   = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [ADDR_W-1:0]     paddr,
    input  logic [31:0]           pwdata,
    output logic [31:0]           prdata,
    input  logic [15:0]           irq_in,
    input  logic [NCPU-1:0]       ack_valid,
    input  logic [NCPU*4-1:0]     ack_num,
    output logic [NCPU*4-1:0]     cpu_level
);
    vec_t rise_w, fall_w, group_w, pend_w, bcast_w;
    logic [NCPU*NLINE-1:0] mask_w, force_w;

    irqc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .req(irq_in), .rise(rise_w), .fall(fall_w)
    );

    irqc_regfile #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .rise(rise_w), .fall(fall_w),
        .ack_valid(ack_valid), .ack_num(ack_num),
        .group_o(group_w), .pend_o(pend_w), .bcast_o(bcast_w),
        .mask_o(mask_w), .force_o(force_w)
    );

    for (genvar n = 0; n < NCPU; n++) begin : g_sel
        irqc_prio u_prio (
            .clk(clk), .rst_n(rst_n),
            .pend(pend_w),
            .frc(force_w[n*NLINE +: NLINE]),
            .mask(mask_w[n*NLINE +: NLINE]),
            .group(group_w),
            .level_o(cpu_level[n*4 +: 4])
        );
    end
endmodule

// File: rtl/irqc_checker.sv
// Property checker for mp_irq_ctrl, attached by bind. It watches request
// edges, shared pending, broadcast, processor 0 mask, level and acknowledge.
module irqc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] rise,
    input logic [15:0] pend,
    input logic [15:0] bcast,
    input logic [15:0] mask0,
    input logic [3:0]  lvl0,
    input logic        ackv0,
    input logic [3:0]  ackn0
);
    AST_PEND_BIT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] == 1'b0); // R1

    AST_MASKED_CPU_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask0 == 16'h0) |=> (lvl0 == 4'd0)); // R3

    AST_ACK_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ackv0 && !rise[ackn0]) |=> !pend[$past(ackn0)]); // R8

    for (genvar k = 1; k < 16; k++) begin : g_line
        AST_RISE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (rise[k] && !bcast[k]) |=> pend[k]); // R5

        AST_BCAST_SKIPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (rise[k] && bcast[k] && !pend[k]) |=> !pend[k]); // R5
    end
endmodule

bind mp_irq_ctrl irqc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rise(rise_w), .pend(pend_w), .bcast(bcast_w),
    .mask0(mask_w[15:0]), .lvl0(cpu_level[3:0]),
    .ackv0(ack_valid[0]), .ackn0(ack_num[3:0])
);

// File: tb/tb_mp_irq_ctrl.sv
`timescale 1ns/1ps
module tb_mp_irq_ctrl;
    localparam int N  = 4;
    localparam int AW = 12;
    localparam logic [15:0] LM = 16'hFFFE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          psel = 0, penable = 0, pwrite = 0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0, prdata;
    logic [15:0]   irq_in = '0;
    logic [N-1:0]  ack_valid = '0;
    logic [4*N-1:0] ack_num = '0, cpu_level;

    mp_irq_ctrl #(.NCPU(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq_in(irq_in), .ack_valid(ack_valid), .ack_num(ack_num),
        .cpu_level(cpu_level)
    );

    int vecs = 0, errs = 0;

    // Reference model state.
    logic [15:0] m_grp = '0, m_pend = '0, m_bc = '0, m_req = '0;
    logic [15:0] m_mask [N];
    logic [15:0] m_frc  [N];
    logic [3:0]  m_ext  [N];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_level(input int n);
        logic [15:0] act, pick;
        logic [3:0] r;
        act  = (m_pend | m_frc[n]) & m_mask[n];
        pick = ((act & m_grp) != 0) ? (act & m_grp) : (act & ~m_grp);
        r = 0;
        for (int i = 1; i < 16; i++) if (pick[i]) r = 4'(i);
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [1:0] bank;
        int slot;
        bank = a[7:6];
        slot = int'(a[5:2]);
        if (bank == 0) begin
            case (a[7:2])
                6'd0: return {16'h0, m_grp};
                6'd1: return {16'h0, m_pend};
                6'd2: return {16'h0, m_frc[0]};
                6'd5: return {16'h0, m_bc};
                default: return 0;
            endcase
        end
        if (slot >= N) return 0;
        case (bank)
            2'd1: return {16'h0, m_mask[slot]};
            2'd2: return {16'h0, m_frc[slot]};
            default: return {28'h0, m_ext[slot]};
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int slot;
        slot = int'(a[5:2]);
        if (a[7:6] == 0) begin
            case (a[7:2])
                6'd0: m_grp = d[15:0] & LM;
                6'd2: m_frc[0] = d[15:0] & LM;
                6'd3: m_pend = m_pend & ~(d[15:0] & LM);
                6'd5: m_bc = d[15:0] & LM;
                default: ;
            endcase
        end else if (slot < N) begin
            case (a[7:6])
                2'd1: m_mask[slot] = d[15:0] & LM;
                2'd2: m_frc[slot] = (m_frc[slot] | (d[15:0] & LM)) & ~(d[31:16] & LM);
                default: m_ext[slot] = d[3:0];
            endcase
        end
    endtask

    task automatic model_edges(input logic [15:0] v);
        logic [15:0] r, f;
        r = v & ~m_req & LM;
        f = ~v & m_req & LM;
        m_pend = (m_pend & ~(f & ~m_bc)) | (r & ~m_bc);
        for (int n = 0; n < N; n++) m_frc[n] = (m_frc[n] & ~(f & m_bc)) | (r & m_bc);
        m_req = v & LM;
    endtask

    task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(posedge clk);
        @(negedge clk);
        penable = 1;
        @(posedge clk);
        model_write(a[7:0], d);
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(posedge clk);
        @(negedge clk);
        penable = 1;
        #0.5;
        chk(tag, prdata, exp_read(a[7:0]));
        @(posedge clk);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic set_lines(input logic [15:0] v);
        @(negedge clk);
        irq_in = v;
        @(posedge clk);
        model_edges(v);
    endtask

    task automatic do_ack(input int n, input logic [3:0] k, input logic [15:0] v);
        @(negedge clk);
        ack_valid[n] = 1'b1;
        ack_num[n*4 +: 4] = k;
        irq_in = v;
        @(posedge clk);
        m_pend   = m_pend   & ~(16'h1 << k) & LM;
        m_frc[n] = m_frc[n] & ~(16'h1 << k) & LM;
        model_edges(v);
        @(negedge clk);
        ack_valid = '0;
    endtask

    task automatic settle_check(input string tag);
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n < N; n++) chk(tag, {28'h0, cpu_level[n*4 +: 4]}, {28'h0, exp_level(n)});
    endtask

    initial begin
        #(200000 * 4);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [3:0] old0;
        for (int n = 0; n < N; n++) begin
            m_mask[n] = '0; m_frc[n] = '0; m_ext[n] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        settle_check("R11 level after reset");
        apb_rd(12'h000, "R11 group after reset");
        apb_rd(12'h004, "R11 pending after reset");
        apb_rd(12'h080, "R11 force after reset");

        // R1 / R2: open all masks; bit 0 dropped
        for (int n = 0; n < N; n++) apb_wr(12'h040 + 12'(4*n), 32'hFFFF_FFFF);
        apb_rd(12'h04C, "R1 mask bit0 dropped");

        // R3 / R12: line 3 arrives, level follows one clock later
        set_lines(16'h0008);
        @(negedge clk);
        old0 = cpu_level[3:0];
        chk("R12 level not yet updated", {28'h0, old0}, 32'h0);
        settle_check("R3 single line active");

        // R4: line 9 in low group beats 3, then 3 in high group wins
        set_lines(16'h0208);
        settle_check("R4 highest in group");
        apb_wr(12'h000, 32'h0000_0009);
        settle_check("R4 high group preferred");
        apb_rd(12'h000, "R1 group bit0 dropped");

        // R5: broadcast line 12
        apb_wr(12'h014, 32'h0000_1000);
        set_lines(16'h1208);
        apb_rd(12'h004, "R5 broadcast bypasses pending");
        apb_rd(12'h08C, "R5 broadcast sets force");
        settle_check("R5 broadcast level");
        set_lines(16'h0208);
        apb_rd(12'h084, "R5 fall clears force");

        // R6: force set then set/clear in one write
        apb_wr(12'h088, 32'h0000_0041);
        apb_rd(12'h088, "R6 force set");
        apb_wr(12'h088, 32'h0040_0080);
        apb_rd(12'h088, "R6 force set and clear");

        // R7: clear register, read-zero words, pending read-only
        apb_wr(12'h00C, 32'h0000_0008);
        apb_rd(12'h004, "R7 clear removes pending");
        apb_rd(12'h00C, "R7 clear reads zero");
        apb_rd(12'h010, "R7 status reads zero");
        apb_wr(12'h004, 32'h0000_FFFF);
        apb_rd(12'h004, "R7 pending read-only");
        settle_check("R7 level after clear");

        // R8: acknowledge clears pending and own force
        apb_wr(12'h084, 32'h0000_0200);
        do_ack(1, 4'd9, 16'h0208);
        apb_rd(12'h004, "R8 ack clears pending");
        apb_rd(12'h084, "R8 ack clears force");

        // R9: alias write replaces processor 0 force
        apb_wr(12'h080, 32'h0000_0010);
        apb_wr(12'h008, 32'h0000_FFFF);
        apb_rd(12'h080, "R9 alias replaces force");
        apb_rd(12'h008, "R9 alias read");

        // R10: ack and new rising edge on line 5 in one clock
        do_ack(0, 4'd5, 16'h0228);
        apb_rd(12'h004, "R10 new edge wins over ack");

        // R2: extended width, unmapped, absent slot, upper address bits
        apb_wr(12'h0C4, 32'hFFFF_FFFF);
        apb_rd(12'h0C4, "R2 extended keeps four bits");
        apb_wr(12'h05C, 32'hFFFF_FFFF);
        apb_rd(12'h05C, "R2 absent slot reads zero");
        apb_rd(12'h018, "R2 unmapped reads zero");
        apb_wr(12'hF44, 32'h0000_0000);
        apb_rd(12'h044, "R2 upper address ignored");
        settle_check("R3 after mask change");

        // Random mix
        void'($urandom(32'h5EED_0042));
        for (int it = 0; it < 600; it++) begin
            int op;
            logic [AW-1:0] a;
            a  = AW'({$urandom % 16, 6'($urandom % 64), 2'b00});
            op = $urandom % 6;
            case (op)
                0: set_lines(16'($urandom));
                1: apb_wr(a, $urandom);
                2: apb_wr(AW'(12'h040 + 12'(4 * ($urandom % N))), $urandom);
                3: do_ack($urandom % N, 4'($urandom), ($urandom % 2) ? 16'($urandom) : irq_in);
                4: apb_rd(a, "R2 random read");
                default: apb_wr(AW'(12'h080 + 12'(4 * ($urandom % N))), $urandom);
            endcase
            settle_check("R4 random levels");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule